// File: doc/BRIEF.md
# Byte-Read PWM Tick Counter

This block is a 16-bit up-counter that an 8-bit register bus sees as two byte locations, a low byte and a high byte. The counter advances on a count-enable tick from the PWM clock source while a run input is high. It wraps at the top of its range. Software reads a full value in two bus accesses. The low-byte access copies the live high byte into a holding register, and the next high-byte access returns that copy. The two bytes are then consistent even if the counter moved between the two accesses.

A write to either byte location clears the whole count, whatever data the write carries. When the counting clock and the bus clock form a combination that cannot give valid read data, an input flag marks the case. Reads made under that flag return zero and do not touch the holding register. When the two clocks are unrelated, software can repeat a read until two results match. A repeated read has no side effect except re-capturing the high byte.

Read data is registered. A read strobe in one cycle produces its byte on `rdata_o` after the next rising clock edge, and that value stays there until the next read.

Top module: `pcnt_byte_port`

## Requirements
- R1: After reset the count, the high-byte holding register and `rdata_o` are all zero.
- R2: In a cycle where `run_i` and `tick_i` are both high and no write occurs, the count rises by one.
- R3: If `run_i` is low or `tick_i` is low, and no write occurs, the count keeps its value.
- R4: One increment from FFFFh gives 0000h.
- R5: A write (`wr_i` high) with `sel_i` at 0 (low byte) or at 1 (high byte) sets the whole count to 0000h, and the value on `wdata_i` has no effect.
- R6: When a write and an increment fall in the same cycle, the write wins and the count becomes 0000h.
- R7: A read with `sel_i` at 0 and `rd_block_i` low places the low byte of the count on `rdata_o` after the next edge. In the same cycle it copies the high byte of the count into the holding register.
- R8: A read with `sel_i` at 1 and `rd_block_i` low returns the holding register, not the live high byte. Repeated high-byte reads return the same value.
- R9: A high-byte read with no earlier low-byte read since reset returns 00h.
- R10: A read while `rd_block_i` is high returns 00h and leaves the holding register unchanged.
- R11: `rdata_o` keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with `clk_i` |
| sel_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_i | input | 1 | Write strobe; clears the count |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data (ignored) |
| tick_i | input | 1 | Count-enable tick from the PWM clock source |
| run_i | input | 1 | Counting allowed while high |
| rd_block_i | input | 1 | Clock pairing does not allow reads; read data forced to zero |
| rdata_o | output | 8 | Registered read data |

## Verification
The checker assumes that every input is synchronous to `clk_i` and already stable at the rising edge. It also assumes that `wr_i` and `rd_i` are one-cycle strobes whose meaning does not depend on earlier cycles. The checker is active only after the internal reset has left its synchronizer. The bench therefore drives all inputs on the falling edge and waits out the synchronizer before the first access. It never lets the tick change between edges, so no reading of the count relies on the re-read protocol for unrelated clocks.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  // byte select encoding on the bus
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;

  // kind of bus read seen in a cycle
  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_LO      = 2'd1,
    ACC_HI      = 2'd2,
    ACC_BLOCKED = 2'd3
  } acc_e;

  function automatic acc_e decode_read(input logic rd, input logic sel, input logic blk);
    acc_e kind;
    if (!rd)             kind = ACC_NONE;
    else if (blk)        kind = ACC_BLOCKED;
    else if (sel == SEL_HI) kind = ACC_HI;
    else                 kind = ACC_LO;
    return kind;
  endfunction

endpackage

// File: rtl/pcnt_rst_sync.sv
module pcnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pcnt_counter.sv
module pcnt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // clear outranks advance
  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pcnt_snap.sv
module pcnt_snap
  import pcnt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic [BYTE_W-1:0] live_lo,
  input  logic [BYTE_W-1:0] live_hi,
  output logic [BYTE_W-1:0] hold_o,
  output logic [BYTE_W-1:0] rdata_o
);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              hold_en, rdata_en;

  always_comb begin
    hold_en  = (acc == ACC_LO);
    rdata_en = (acc != ACC_NONE);
    hold_d   = live_hi;
    unique case (acc)
      ACC_LO:      rdata_d = live_lo;
      ACC_HI:      rdata_d = hold_q;
      ACC_BLOCKED: rdata_d = '0;
      default:     rdata_d = rdata_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (hold_en)  hold_q  <= hold_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign hold_o  = hold_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/pcnt_byte_port.sv
module pcnt_byte_port
  import pcnt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              rd_block_i,
  output logic [BYTE_W-1:0] rdata_o
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             rst_sync_n;
  logic [CNT_W-1:0] count_w;
  logic [BYTE_W-1:0] hold_w;
  acc_e             acc_w;
  logic             wdata_unused;

  // the written value carries no meaning
  assign wdata_unused = ^wdata_i;

  assign acc_w = decode_read(rd_i, sel_i, rd_block_i);

  pcnt_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk_i),
    .rst_n_async (rst_ni),
    .rst_n_sync  (rst_sync_n)
  );

  pcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk_i),
    .rst_n (rst_sync_n),
    .clr   (wr_i),
    .adv   (run_i & tick_i),
    .cnt_o (count_w)
  );

  pcnt_snap #(.BYTE_W(BYTE_W)) u_snap (
    .clk     (clk_i),
    .rst_n   (rst_sync_n),
    .acc     (acc_w),
    .live_lo (count_w[BYTE_W-1:0]),
    .live_hi (count_w[CNT_W-1:BYTE_W]),
    .hold_o  (hold_w),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/pcnt_byte_port_chk.sv
module pcnt_byte_port_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr,
  input logic                rd,
  input logic                sel,
  input logic                tick,
  input logic                run,
  input logic                blk,
  input logic [2*BYTE_W-1:0] cnt,
  input logic [BYTE_W-1:0]   hold,
  input logic [BYTE_W-1:0]   rdata
);

  localparam int CNT_W = 2 * BYTE_W;

  // R2 R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && run && tick) |=> cnt == $past(cnt) + CNT_W'(1));

  // R3
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !(run && tick)) |=> $stable(cnt));

  // R5 R6
  clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == '0);

  // R7
  low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !blk && !sel) |=> (rdata == $past(cnt[BYTE_W-1:0])) && (hold == $past(cnt[CNT_W-1:BYTE_W])));

  // R8
  high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !blk && sel) |=> (rdata == $past(hold)) && $stable(hold));

  // R10
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && blk) |=> (rdata == '0) && $stable(hold));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata) && $stable(hold));

endmodule

bind pcnt_byte_port pcnt_byte_port_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .wr    (wr_i),
  .rd    (rd_i),
  .sel   (sel_i),
  .tick  (tick_i),
  .run   (run_i),
  .blk   (rd_block_i),
  .cnt   (count_w),
  .hold  (hold_w),
  .rdata (rdata_o)
);

// File: tb/pcnt_byte_port_test.sv
module pcnt_byte_port_test;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       sel_i, wr_i, rd_i, tick_i, run_i, rd_block_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] m_cnt;
  logic [7:0]  m_hold, m_rdata;

  always #2 clk_i = ~clk_i;

  pcnt_byte_port uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .tick_i     (tick_i),
    .run_i      (run_i),
    .rd_block_i (rd_block_i),
    .rdata_o    (rdata_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock: inputs applied at the falling edge, model stepped at the rising edge
  task automatic cyc(input logic wr, input logic rd, input logic sel, input logic tick,
                     input logic run, input logic blk, input logic [7:0] wd);
    wr_i = wr; rd_i = rd; sel_i = sel; tick_i = tick; run_i = run; rd_block_i = blk; wdata_i = wd;
    @(posedge clk_i);
    if (rd) begin
      if (blk)      m_rdata = 8'h00;
      else if (sel) m_rdata = m_hold;
      else begin
        m_rdata = m_cnt[7:0];
        m_hold  = m_cnt[15:8];
      end
    end
    if (wr)              m_cnt = 16'h0000;
    else if (run && tick) m_cnt = m_cnt + 16'h0001;
    @(negedge clk_i);
    wr_i = 0; rd_i = 0; tick_i = 0; run_i = 0; rd_block_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 1, 0, 8'h00);
  endtask

  task automatic rd_lo(input string req);
    cyc(0, 1, 0, 0, 0, 0, 8'h00);
    check(req, rdata_o, m_rdata);
  endtask

  task automatic rd_hi(input string req);
    cyc(0, 1, 1, 0, 0, 0, 8'h00);
    check(req, rdata_o, m_rdata);
  endtask

  task automatic t_reset;
    check("R1", rdata_o, 8'h00);
    rd_hi("R9");
    check("R9", rdata_o, 8'h00);
    rd_lo("R1");
    check("R1", rdata_o, 8'h00);
  endtask

  task automatic t_count;
    ticks(5);
    rd_lo("R2");
    check("R2", rdata_o, 8'h05);
    rd_hi("R2");
  endtask

  task automatic t_hold;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 8'h00);
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 1, 0, 8'h00);
    rd_lo("R3");
    check("R3", rdata_o, 8'h05);
  endtask

  task automatic t_clear;
    ticks(7);
    cyc(1, 0, 1, 0, 0, 0, 8'hAA);
    rd_lo("R5");
    check("R5", rdata_o, 8'h00);
    ticks(3);
    cyc(1, 0, 0, 0, 0, 0, 8'h55);
    rd_lo("R5");
    check("R5", rdata_o, 8'h00);
  endtask

  task automatic t_priority;
    ticks(4);
    cyc(1, 0, 0, 1, 1, 0, 8'hFF);
    rd_lo("R6");
    check("R6", rdata_o, 8'h00);
  endtask

  task automatic t_latch;
    cyc(1, 0, 0, 0, 0, 0, 8'h00);
    ticks(291);
    rd_lo("R7");
    check("R7", rdata_o, 8'h23);
    ticks(300);
    rd_hi("R8");
    check("R8", rdata_o, 8'h01);
    rd_hi("R8");
    check("R8", rdata_o, 8'h01);
    rd_lo("R7");
    rd_hi("R8");
    check("R8", rdata_o, 8'h02);
  endtask

  task automatic t_block;
    ticks(256);
    cyc(0, 1, 0, 0, 0, 1, 8'h00);
    check("R10", rdata_o, 8'h00);
    rd_hi("R10");
    check("R10", rdata_o, 8'h02);
  endtask

  task automatic t_idle;
    rd_lo("R11");
    ticks(9);
    check("R11", rdata_o, m_rdata);
  endtask

  task automatic t_wrap;
    cyc(1, 0, 0, 0, 0, 0, 8'h00);
    ticks(65535);
    rd_lo("R4");
    check("R4", rdata_o, 8'hFF);
    rd_hi("R4");
    check("R4", rdata_o, 8'hFF);
    ticks(1);
    rd_lo("R4");
    check("R4", rdata_o, 8'h00);
    rd_hi("R4");
    check("R4", rdata_o, 8'h00);
  endtask

  initial begin
    rst_ni = 0; sel_i = 0; wr_i = 0; rd_i = 0; tick_i = 0; run_i = 0; rd_block_i = 0; wdata_i = 0;
    m_cnt = 0; m_hold = 0; m_rdata = 0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    t_reset;
    t_count;
    t_hold;
    t_clear;
    t_priority;
    t_latch;
    t_block;
    t_idle;
    t_wrap;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule